// File: doc/BRIEF.md
# Hold Conversion Scheduler

This block decides when a single shared converter serves three groups of inputs: A, B and C. Each group has an active-low hold line. A falling edge on that line asks for a conversion of the group's two inputs. The two inputs are converted back to back, sub-channel 0 first and then sub-channel 1. The converter is modelled by cycle counters.

Hold lines are sampled on the falling clock edge. Requests that are captured in different cycles are served in arrival order. Requests that are captured in the same cycle are queued A first, then B, then C. While a group is waiting or being converted, further falling edges on its line are ignored. The block drives these outputs:
- an active-low busy flag;
- a start pulse, with the group code and the sub-channel index;
- a done pulse, with the group code.

The controller has four states:
- IDLE: it waits for a queued group.
- CONV: a conversion is running. It lasts CONV_CLKS cycles and its first cycle carries the start pulse.
- SETTLE: the filler that brings the spacing of the two conversions up to SLOT_CLKS.
- ACQ: busy is high and the inputs re-acquire for ACQ_CLKS cycles.

The transitions are:
- IDLE to CONV when the queue holds a group.
- CONV to SETTLE after sub-channel 0.
- SETTLE to CONV for sub-channel 1.
- CONV to ACQ after sub-channel 1.
- ACQ to CONV when the queue holds another group, or ACQ to IDLE when it is empty.

Top module: `hold_sched`

## Requirements
- R1: A synchronous reset empties the queue, clears every pending mark and drives busy_n high with no start or done pulse. A hold line that is low while reset is released does not count as a request.
- R2: Only a high-to-low transition of a hold line is a request. A line kept low produces exactly one service of its group.
- R3: Groups captured in different cycles are served strictly in capture order.
- R4: Groups captured in the same cycle are served in the order A (code 0), B (code 1), C (code 2). hold_n bit 0 is A, bit 1 is B and bit 2 is C.
- R5: A falling edge on the line of a group that is queued or under conversion is ignored. A falling edge after that group's done pulse is accepted again.
- R6: Each service gives two start pulses for the same group. The first carries start_sub 0 and the second carries start_sub 1, exactly SLOT_CLKS cycles later.
- R7: done_p is a one-cycle pulse with the served group code, in cycle start + SLOT_CLKS + CONV_CLKS - 1, where start is the cycle of the sub-channel 0 start pulse.
- R8: busy_n is low from the first start pulse of a group through its done cycle, and it is high in the cycle after done.
- R9: After done, busy_n stays high for ACQ_CLKS cycles. A queued group then starts in cycle done + ACQ_CLKS + 1.
- R10: An edge that is present at the falling clock edge of cycle k starts an idle scheduler in cycle k+2. An edge that arrives after that falling edge is counted one cycle later.
- R11: The queue holds up to NUM_GRP entries, so all three groups can wait at once without loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous reset, active high |
| hold_n | input | NUM_GRP | Active-low hold lines; bit 0 is A, bit 1 is B, bit 2 is C |
| busy_n | output | 1 | Low while a group is being converted |
| start_p | output | 1 | One-cycle pulse at the start of each conversion |
| start_grp | output | $clog2(NUM_GRP) | Group code of the current conversion |
| start_sub | output | 1 | Sub-channel index of the current conversion |
| done_p | output | 1 | One-cycle pulse when a group's second conversion ends |
| done_grp | output | $clog2(NUM_GRP) | Group code that accompanies done_p |

## Verification
The assertions check these properties on every cycle:
- the queue never outgrows the number of pending groups;
- the queue head is always a pending group;
- start pulses occur only while busy is low;
- busy rises right after done;
- no group begins until busy has been high for the acquisition gap.

Only the bench's scenarios can show service order and exact timing. The bench sweeps every pattern of capture cycles for the three groups. It also runs directed cases for a repeat edge during pending, a line held low across reset, and an edge that arrives just after the sampling point.

// File: rtl/hold_sched_pkg.sv
package hold_sched_pkg;

    // Controller states of the conversion sequencer
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CONV   = 2'd1,
        ST_SETTLE = 2'd2,
        ST_ACQ    = 2'd3
    } conv_st_e;

endpackage

// File: rtl/hold_edge_det.sv
module hold_edge_det #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] hold_n,
    output logic [N-1:0] fall
);
    logic [N-1:0] smp_q;
    logic [N-1:0] prv_q;

    // Lines are sampled on the falling clock edge. During reset both stages
    // follow the line, so a line that is already low is not seen as an edge.
    always_ff @(negedge clk) begin
        if (rst) begin
            smp_q <= hold_n;
            prv_q <= hold_n;
        end else begin
            smp_q <= hold_n;
            prv_q <= smp_q;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_line
        assign fall[g] = prv_q[g] & ~smp_q[g];
    end
endmodule

// File: rtl/hold_queue.sv
module hold_queue #(
    parameter int N  = 3,
    parameter int GW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  fall,
    input  logic          pop,
    input  logic          done_p,
    input  logic [GW-1:0] done_grp,
    output logic          nonempty,
    output logic [GW-1:0] head
);
    localparam int CW = $clog2(N + 1);

    logic [GW-1:0] slot_q  [N];
    logic [GW-1:0] slot_nx [N];
    logic [CW-1:0] cnt_q, cnt_nx;
    logic [N-1:0]  pend_q, pend_nx, accept, clr;

    always_comb begin
        slot_nx = slot_q;
        cnt_nx  = cnt_q;
        accept  = fall & ~pend_q;
        clr     = '0;
        if (done_p) clr[done_grp] = 1'b1;
        // Remove the head entry first
        if (pop && cnt_q != '0) begin
            for (int s = 0; s < N - 1; s++) slot_nx[s] = slot_q[s + 1];
            slot_nx[N-1] = '0;
            cnt_nx = cnt_q - CW'(1);
        end
        // Then append new requests, lowest group code first
        for (int g = 0; g < N; g++) begin
            if (accept[g]) begin
                for (int s = 0; s < N; s++)
                    if (CW'(s) == cnt_nx) slot_nx[s] = GW'(g);
                cnt_nx = cnt_nx + CW'(1);
            end
        end
        pend_nx = (pend_q | accept) & ~clr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            pend_q <= '0;
            for (int s = 0; s < N; s++) slot_q[s] <= '0;
        end else begin
            cnt_q  <= cnt_nx;
            pend_q <= pend_nx;
            slot_q <= slot_nx;
        end
    end

    assign nonempty = (cnt_q != '0);
    assign head     = slot_q[0];

    // R11: the count never exceeds the slot count
    p_cnt_bound_r11: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(N));
    // R5: no group sits twice in the list
    p_no_dup_r5: assert property (@(posedge clk) disable iff (rst)
        int'(cnt_q) <= $countones(pend_q));
    // R5: whatever is at the head is still marked pending
    p_head_pending_r5: assert property (@(posedge clk) disable iff (rst)
        nonempty |-> pend_q[head]);
endmodule

// File: rtl/hold_conv_fsm.sv
module hold_conv_fsm
    import hold_sched_pkg::*;
#(
    parameter int GW        = 2,
    parameter int CONV_CLKS = 13,
    parameter int SLOT_CLKS = 16,
    parameter int ACQ_CLKS  = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          q_nonempty,
    input  logic [GW-1:0] q_head,
    output logic          pop,
    output logic          busy_n,
    output logic          start_p,
    output logic [GW-1:0] start_grp,
    output logic          start_sub,
    output logic          done_p,
    output logic [GW-1:0] done_grp
);
    localparam int MAXC = (SLOT_CLKS > ACQ_CLKS) ? SLOT_CLKS : ACQ_CLKS;
    localparam int CNTW = $clog2(MAXC + 1);
    localparam logic [CNTW-1:0] CONV_LAST   = CNTW'(CONV_CLKS - 1);
    localparam logic [CNTW-1:0] SETTLE_LAST = CNTW'(SLOT_CLKS - CONV_CLKS - 1);
    localparam logic [CNTW-1:0] ACQ_LAST    = CNTW'(ACQ_CLKS - 1);

    conv_st_e      st_q, st_nx;
    logic [CNTW-1:0] cnt_q, cnt_nx;
    logic          sub_q, sub_nx;
    logic [GW-1:0] grp_q;

    // Next-state logic
    always_comb begin
        st_nx  = st_q;
        cnt_nx = cnt_q + CNTW'(1);
        sub_nx = sub_q;
        unique case (st_q)
            ST_IDLE: begin
                cnt_nx = '0;
                if (q_nonempty) begin
                    st_nx  = ST_CONV;
                    sub_nx = 1'b0;
                end
            end
            ST_CONV: begin
                if (cnt_q == CONV_LAST) begin
                    cnt_nx = '0;
                    st_nx  = sub_q ? ST_ACQ : ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (cnt_q == SETTLE_LAST) begin
                    cnt_nx = '0;
                    st_nx  = ST_CONV;
                    sub_nx = 1'b1;
                end
            end
            ST_ACQ: begin
                if (cnt_q == ACQ_LAST) begin
                    cnt_nx = '0;
                    sub_nx = 1'b0;
                    st_nx  = q_nonempty ? ST_CONV : ST_IDLE;
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            sub_q <= 1'b0;
            grp_q <= '0;
        end else begin
            st_q  <= st_nx;
            cnt_q <= cnt_nx;
            sub_q <= sub_nx;
            if (pop) grp_q <= q_head;
        end
    end

    // Outputs
    always_comb begin
        pop       = q_nonempty &&
                    ((st_q == ST_IDLE) || (st_q == ST_ACQ && cnt_q == ACQ_LAST));
        busy_n    = !(st_q == ST_CONV || st_q == ST_SETTLE);
        start_p   = (st_q == ST_CONV) && (cnt_q == '0);
        start_sub = sub_q;
        start_grp = grp_q;
        done_p    = (st_q == ST_CONV) && sub_q && (cnt_q == CONV_LAST);
        done_grp  = grp_q;
    end

    // Checker: consecutive cycles with busy high, saturating at ACQ_CLKS
    logic [CNTW-1:0] hi_run_q;
    always_ff @(posedge clk) begin
        if (rst)                              hi_run_q <= CNTW'(ACQ_CLKS);
        else if (!busy_n)                     hi_run_q <= '0;
        else if (hi_run_q < CNTW'(ACQ_CLKS))  hi_run_q <= hi_run_q + CNTW'(1);
    end

    // R9: a group begins only after the full acquisition gap
    p_acq_gap_r9: assert property (@(posedge clk) disable iff (rst)
        (start_p && !start_sub) |-> (hi_run_q >= CNTW'(ACQ_CLKS)));
    // R8: conversion starts happen only while busy is low
    p_start_busy_r8: assert property (@(posedge clk) disable iff (rst)
        start_p |-> !busy_n);
    // R8: busy rises right after done
    p_done_release_r8: assert property (@(posedge clk) disable iff (rst)
        done_p |=> busy_n);
    // R6: the second sub-channel follows inside the same busy window
    p_sub1_in_busy_r6: assert property (@(posedge clk) disable iff (rst)
        (start_p && start_sub) |-> $past(!busy_n));
endmodule

// File: rtl/hold_sched.sv
module hold_sched #(
    parameter int NUM_GRP   = 3,
    parameter int CONV_CLKS = 13,
    parameter int SLOT_CLKS = 16,
    parameter int ACQ_CLKS  = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_GRP-1:0]         hold_n,
    output logic                       busy_n,
    output logic                       start_p,
    output logic [$clog2(NUM_GRP)-1:0] start_grp,
    output logic                       start_sub,
    output logic                       done_p,
    output logic [$clog2(NUM_GRP)-1:0] done_grp
);
    localparam int GW = $clog2(NUM_GRP);

    logic [NUM_GRP-1:0] fall;
    logic               pop, q_nonempty;
    logic [GW-1:0]      q_head;

    hold_edge_det #(.N(NUM_GRP)) edge_i (
        .clk    (clk),
        .rst    (rst),
        .hold_n (hold_n),
        .fall   (fall)
    );

    hold_queue #(.N(NUM_GRP), .GW(GW)) queue_i (
        .clk      (clk),
        .rst      (rst),
        .fall     (fall),
        .pop      (pop),
        .done_p   (done_p),
        .done_grp (done_grp),
        .nonempty (q_nonempty),
        .head     (q_head)
    );

    hold_conv_fsm #(
        .GW        (GW),
        .CONV_CLKS (CONV_CLKS),
        .SLOT_CLKS (SLOT_CLKS),
        .ACQ_CLKS  (ACQ_CLKS)
    ) fsm_i (
        .clk        (clk),
        .rst        (rst),
        .q_nonempty (q_nonempty),
        .q_head     (q_head),
        .pop        (pop),
        .busy_n     (busy_n),
        .start_p    (start_p),
        .start_grp  (start_grp),
        .start_sub  (start_sub),
        .done_p     (done_p),
        .done_grp   (done_grp)
    );
endmodule

// File: tb/hold_sched_tb_top.sv
`timescale 1ns/1ps
module hold_sched_tb_top;
    localparam int NG    = 3;
    localparam int CONV  = 13;
    localparam int SLOT  = 16;
    localparam int ACQ   = 2;
    localparam int GSPAN = SLOT + CONV + ACQ;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NG-1:0]  hold_n = '1;
    logic           busy_n, start_p, start_sub, done_p;
    logic [1:0]     start_grp, done_grp;

    hold_sched #(.NUM_GRP(NG), .CONV_CLKS(CONV), .SLOT_CLKS(SLOT), .ACQ_CLKS(ACQ)) dut_i (
        .clk(clk), .rst(rst), .hold_n(hold_n), .busy_n(busy_n), .start_p(start_p),
        .start_grp(start_grp), .start_sub(start_sub), .done_p(done_p), .done_grp(done_grp)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_fail = 0;
    int n_st = 0, n_dn = 0, base = 0;
    int st_c[16], st_g[16], st_s[16], dn_c[16], dn_g[16];
    logic busy_log[256];

    // Event logger, sampled away from the rising edge
    always @(negedge clk) begin
        if (start_p && n_st < 16) begin
            st_c[n_st] = cyc; st_g[n_st] = int'(start_grp); st_s[n_st] = int'(start_sub);
            n_st = n_st + 1;
        end
        if (done_p && n_dn < 16) begin
            dn_c[n_dn] = cyc; dn_g[n_dn] = int'(done_grp);
            n_dn = n_dn + 1;
        end
        if (cyc - base >= 0 && cyc - base < 256) busy_log[cyc - base] = busy_n;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic clear_log();
        n_st = 0; n_dn = 0; base = cyc;
        for (int i = 0; i < 16; i++) begin
            st_c[i] = -1; st_g[i] = -1; st_s[i] = -1; dn_c[i] = -1; dn_g[i] = -1;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) step();
        rst = 1'b0;
    endtask

    task automatic wait_to(input int c);
        while (cyc < c) step();
    endtask

    initial begin
        #4000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int t;
        // R1: reset state
        do_reset();
        chk(busy_n == 1'b1, "R1", "busy_n after reset", int'(busy_n), 1);
        chk(start_p == 1'b0 && done_p == 1'b0, "R1", "pulses after reset",
            int'(start_p) + int'(done_p), 0);

        // R1: lines low across reset release are not requests
        hold_n = '0;
        rst = 1'b1;
        repeat (3) step();
        rst = 1'b0;
        clear_log();
        repeat (40) step();
        chk(n_st == 0, "R1", "starts from lines low at release", n_st, 0);
        hold_n = '1;
        repeat (4) step();

        // Sweep of capture cycles: 0,1,2 or none for each group
        for (int oa = 0; oa < 4; oa++) begin
            for (int ob = 0; ob < 4; ob++) begin
                for (int oc = 0; oc < 4; oc++) begin
                    int off[3];
                    int arr[3];
                    int ord[3];
                    int cnt_d[3];
                    int n, prev, s, g, dn;
                    bit tie;
                    off[0] = oa; off[1] = ob; off[2] = oc;
                    hold_n = '1;
                    do_reset();
                    clear_log();
                    for (int d = 0; d < 3; d++) begin
                        step();
                        for (int gg = 0; gg < 3; gg++)
                            if (off[gg] == d) begin hold_n[gg] = 1'b0; arr[gg] = cyc; end
                    end
                    repeat (110) step();
                    n = 0; tie = 1'b0;
                    for (int d = 0; d < 3; d++) begin
                        cnt_d[d] = 0;
                        for (int gg = 0; gg < 3; gg++)
                            if (off[gg] == d) begin ord[n] = gg; n++; cnt_d[d]++; end
                        if (cnt_d[d] > 1) tie = 1'b1;
                    end
                    // R2: held-low lines give exactly one service each
                    chk(n_st == 2 * n, "R2", "start count", n_st, 2 * n);
                    chk(n_dn == n, "R7", "done count", n_dn, n);
                    if (n == 3) chk(n_dn == 3, "R11", "all three queued served", n_dn, 3);
                    prev = 0;
                    for (int i = 0; i < n; i++) begin
                        g = ord[i];
                        s = arr[g] + 2;
                        if (i > 0 && prev + GSPAN > s) s = prev + GSPAN;
                        prev = s;
                        dn = s + SLOT + CONV - 1;
                        chk(st_g[2*i] == g, tie ? "R4" : "R3", "served group", st_g[2*i], g);
                        chk(st_c[2*i] == s, (i == 0) ? "R10" : "R9", "start cycle",
                            st_c[2*i] - base, s - base);
                        chk(st_s[2*i] == 0 && st_s[2*i+1] == 1 && st_g[2*i+1] == g &&
                            st_c[2*i+1] == s + SLOT, "R6", "second sub-channel start",
                            st_c[2*i+1] - base, s + SLOT - base);
                        chk(dn_c[i] == dn && dn_g[i] == g, "R7", "done cycle",
                            dn_c[i] - base, dn - base);
                        chk(busy_log[s - base] == 1'b0 && busy_log[dn - base] == 1'b0 &&
                            busy_log[dn + 1 - base] == 1'b1, "R8", "busy window",
                            int'(busy_log[dn + 1 - base]), 1);
                        chk(busy_log[dn + ACQ - base] == 1'b1, "R9", "busy high in gap",
                            int'(busy_log[dn + ACQ - base]), 1);
                    end
                end
            end
        end

        // R5: repeat edge while pending is ignored, edge after done is accepted
        hold_n = '1;
        do_reset();
        clear_log();
        step();
        t = cyc;
        hold_n[0] = 1'b0;
        wait_to(t + 3);  hold_n[0] = 1'b1;
        wait_to(t + 6);  hold_n[0] = 1'b0;
        wait_to(t + 32); hold_n[0] = 1'b1;
        wait_to(t + 34); hold_n[0] = 1'b0;
        repeat (80) step();
        chk(n_st == 4, "R5", "start count with repeat edges", n_st, 4);
        chk(st_c[0] == t + 2, "R5", "first service start", st_c[0] - t, 2);
        chk(st_c[2] == t + 36, "R5", "second service start", st_c[2] - t, 36);

        // R10: edge after the sampling point moves one cycle; same-cycle tie to C
        hold_n = '1;
        do_reset();
        clear_log();
        step();
        t = cyc;
        #10 hold_n[1] = 1'b0;
        step();
        hold_n[2] = 1'b0;
        repeat (80) step();
        chk(st_c[0] == t + 3 && st_g[0] == 1, "R10", "late edge start", st_c[0] - t, 3);
        chk(st_g[2] == 2 && st_c[2] == t + 3 + GSPAN, "R4", "tie after late edge",
            st_c[2] - t, 3 + GSPAN);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule